// File: doc/BRIEF.md
# Vector Signed Saturating Word Adder

This execution unit handles one vector instruction: a pairwise signed add of four 32-bit lanes with clamping to the signed 32-bit range. Each cycle it may be offered a 32-bit instruction word and two 128-bit source vectors. It decodes the word and, when the word names this operation and the issue strobe is high, it registers the clamped lane sums. On the following clock edge it raises a write enable for the destination register, together with the destination index.

The unit keeps one sticky saturation status bit. Any executed instruction in which at least one lane had to be clipped sets the bit, and later instructions never clear it. The only way to lower or raise it directly is a separate status-write port, which behaves like a move into the vector status register. The two source register indices are decoded combinationally from the word, so a register file can read its ports in the issue cycle.

Top module: `vsat_add_unit`

## Requirements
- R1: Each result lane is the signed sum of the matching source lanes when that sum fits in 32 bits. The result appears on `result` in the cycle after issue, with `dest_we` high for one cycle.
- R2: Lane 0 occupies bits 127:96 of every vector and lane 3 occupies bits 31:0. Lanes 1 and 2 lie in between, in order.
- R3: A lane whose true sum exceeds 2^31-1 yields 0x7FFFFFFF. For example, 0x7FFFFFFF + 1 gives 0x7FFFFFFF. A sum of exactly 2^31-1 is not counted as clipped.
- R4: A lane whose true sum is below -2^31 yields 0x80000000. For example, 0x80000000 + 0xFFFFFFFF gives 0x80000000.
- R5: Lanes are independent. No carry, borrow or clipping in one lane alters any other lane.
- R6: After an executed instruction in which any lane clipped, `sat_flag` reads 1 from the next cycle on. An executed instruction with no clipping leaves the flag unchanged.
- R7: Once set, `sat_flag` stays set through any number of later non-saturating instructions and idle cycles until the status-write port changes it.
- R8: The word matches only when bits 31:26 equal 4 and bits 10:0 equal 896 (0x10000380 with all index fields zero). A change in either field prevents execution.
- R9: The destination index is bits 25:21, source A is bits 20:16 and source B is bits 15:11. `src_a_idx` and `src_b_idx` follow the word combinationally, and `dest_idx` is registered with the result.
- R10: When the issue strobe is low or the word does not match, `dest_we` stays low and neither `result` nor `sat_flag` changes.
- R11: When `sat_wr_en` is high, `sat_flag` takes `sat_wr_val` at the next edge. This write takes priority over any saturation set in the same cycle.
- R12: During reset, `result` is zero, `dest_we` is low and `sat_flag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction word and sources are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector, lane 0 in the top word |
| src_b | input | 128 | Second source vector, lane 0 in the top word |
| src_a_idx | output | 5 | Decoded first source register index |
| src_b_idx | output | 5 | Decoded second source register index |
| result | output | 128 | Registered clamped lane sums |
| dest_we | output | 1 | Destination write enable, one cycle per executed instruction |
| dest_idx | output | 5 | Destination register index for the registered result |
| sat_wr_en | input | 1 | Load the status bit from `sat_wr_val` |
| sat_wr_val | input | 1 | Value for the status bit |
| sat_flag | output | 1 | Sticky saturation status bit |

## Verification
The main function is driven with several kinds of operands. Small mixed-sign operands separate a correct signed add from an unsigned or modulo one. A sum landing exactly on 0x7FFFFFFF tells a correct clamp from an off-by-one. Operand pairs such as max+1 and min+(-1) show whether overflow is detected on each side and clamped to the right extreme. A lane of 0xFFFFFFFF + 1 placed next to a clipping lane exposes any carry or clip leaking between lanes. Distinct values per lane expose a reversed lane order. A pseudo-random run, with one operand in four forced to an extreme, checks every lane against a 64-bit reference clamped to 32 bits. The run also scatters status writes among the additions, which checks that the sticky bit is set only by clipping and changed only by the write port.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

  // Instruction word layout (fixed 32-bit word, MSB-first field numbering)
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned PRI_W    = 6;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned XO_W     = 11;
  localparam int unsigned PRI_CODE = 4;
  localparam int unsigned XO_CODE  = 896;

  // Derived field positions (low bit of each field)
  localparam int unsigned PRI_LSB = INSTR_W - PRI_W;
  localparam int unsigned VD_LSB  = PRI_LSB - IDX_W;
  localparam int unsigned VA_LSB  = VD_LSB - IDX_W;
  localparam int unsigned VB_LSB  = VA_LSB - IDX_W;

  typedef logic [IDX_W-1:0] vreg_idx_t;

  typedef struct packed {
    logic      hit;
    vreg_idx_t dst;
    vreg_idx_t srca;
    vreg_idx_t srcb;
  } vsat_dec_t;

  // Field extraction kept in a function so the layout lives in one place.
  function automatic vsat_dec_t vsat_decode_word(input logic [INSTR_W-1:0] w);
    vsat_dec_t d;
    d.hit  = (w[INSTR_W-1 -: PRI_W] == PRI_W'(PRI_CODE)) &&
             (w[XO_W-1:0] == XO_W'(XO_CODE));
    d.dst  = w[VD_LSB +: IDX_W];
    d.srca = w[VA_LSB +: IDX_W];
    d.srcb = w[VB_LSB +: IDX_W];
    return d;
  endfunction

endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
  import vsat_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic               hit,
  output vreg_idx_t          dst,
  output vreg_idx_t          srca,
  output vreg_idx_t          srcb
);

  vsat_dec_t dec;

  always_comb begin
    dec  = vsat_decode_word(word);
    hit  = dec.hit;
    dst  = dec.dst;
    srca = dec.srca;
    srcb = dec.srcb;
  end

endmodule

// File: rtl/vsat_lane.sv
module vsat_lane #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum,
  output logic         clip
);

  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  // Overflow exists only when both operands share a sign and the wrapped
  // sum shows the other sign; the operand sign then picks the limit.
  function automatic logic lane_overflow(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic [W-1:0] s);
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  function automatic logic [W-1:0] lane_limit(input logic neg);
    return neg ? NEG_LIMIT : POS_LIMIT;
  endfunction

  logic [W-1:0] wrap_sum;

  always_comb begin
    wrap_sum = op_a + op_b;
    clip     = lane_overflow(op_a, op_b, wrap_sum);
    sum      = clip ? lane_limit(op_a[W-1]) : wrap_sum;
  end

endmodule

// File: rtl/vsat_status.sv
module vsat_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic load_en,
  input  logic load_val,
  output logic flag
);

  // Explicit load has priority; otherwise the bit only ever rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (load_en) begin
      flag <= load_val;
    end else if (set_req) begin
      flag <= 1'b1;
    end
  end

endmodule

// File: rtl/vsat_add_unit.sv
module vsat_add_unit
  import vsat_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_valid,
  input  logic [INSTR_W-1:0]        instr,
  input  logic [LANE_W*LANES-1:0]   src_a,
  input  logic [LANE_W*LANES-1:0]   src_b,
  output logic [IDX_W-1:0]          src_a_idx,
  output logic [IDX_W-1:0]          src_b_idx,
  output logic [LANE_W*LANES-1:0]   result,
  output logic                      dest_we,
  output logic [IDX_W-1:0]          dest_idx,
  input  logic                      sat_wr_en,
  input  logic                      sat_wr_val,
  output logic                      sat_flag
);

  localparam int unsigned VEC_W = LANE_W * LANES;

  // Named internal events, also observed by the bound checker
  logic                 word_hit;
  logic                 exec_fire;
  logic [LANES-1:0]     lane_clip;
  logic                 any_clip;
  logic [VEC_W-1:0]     lane_sums;
  vreg_idx_t            dst_dec;

  vsat_decode u_decode (
    .word (instr),
    .hit  (word_hit),
    .dst  (dst_dec),
    .srca (src_a_idx),
    .srcb (src_b_idx)
  );

  assign exec_fire = issue_valid && word_hit;

  // Lane 0 sits in the most significant word.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned HI = VEC_W - 1 - g * LANE_W;
    vsat_lane #(.W(LANE_W)) u_lane (
      .op_a (src_a[HI -: LANE_W]),
      .op_b (src_b[HI -: LANE_W]),
      .sum  (lane_sums[HI -: LANE_W]),
      .clip (lane_clip[g])
    );
  end

  assign any_clip = |lane_clip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      dest_we  <= 1'b0;
      dest_idx <= '0;
    end else begin
      dest_we <= exec_fire;
      if (exec_fire) begin
        result   <= lane_sums;
        dest_idx <= dst_dec;
      end
    end
  end

  vsat_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (exec_fire && any_clip),
    .load_en  (sat_wr_en),
    .load_val (sat_wr_val),
    .flag     (sat_flag)
  );

endmodule

// File: rtl/vsat_add_unit_chk.sv
module vsat_add_unit_chk
  import vsat_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    issue_valid,
  input logic [INSTR_W-1:0]      instr,
  input logic                    sat_wr_en,
  input logic                    sat_wr_val,
  input logic                    sat_flag,
  input logic                    dest_we,
  input logic [IDX_W-1:0]        dest_idx,
  input logic [LANE_W*LANES-1:0] result,
  input logic                    exec_fire,
  input logic [LANES-1:0]        lane_clip
);

  localparam int unsigned VEC_W = LANE_W * LANES;
  localparam logic [LANE_W-1:0] TOP = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] BOT = {1'b1, {(LANE_W-1){1'b0}}};

  // R8 / R10: a write only follows a valid, matching word
  p_we_after_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dest_we |-> ($past(issue_valid) &&
                 $past(instr[INSTR_W-1 -: PRI_W]) == PRI_W'(PRI_CODE) &&
                 $past(instr[XO_W-1:0]) == XO_W'(XO_CODE)));

  // R9: destination index registered from the word
  p_dest_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dest_we |-> (dest_idx == $past(instr[VD_LSB +: IDX_W])));

  // R6: clipping during an execute raises the flag
  p_clip_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && (|lane_clip) && !sat_wr_en) |=> sat_flag);

  // R7: the flag never falls without an explicit write
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_wr_en) |=> sat_flag);

  // R11: explicit write wins
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sat_wr_en |=> (sat_flag == $past(sat_wr_val)));

  // R10: no execute and no write means nothing moves
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_fire && !sat_wr_en) |=> ($stable(sat_flag) && $stable(result) && !dest_we));

  // R3 / R4: a clipped lane lands on one of the two limits
  for (genvar g = 0; g < LANES; g++) begin : g_lim
    localparam int unsigned HI = VEC_W - 1 - g * LANE_W;
    p_clip_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_fire && lane_clip[g]) |=> (result[HI -: LANE_W] == TOP ||
                                       result[HI -: LANE_W] == BOT));
  end

endmodule

bind vsat_add_unit vsat_add_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .instr       (instr),
  .sat_wr_en   (sat_wr_en),
  .sat_wr_val  (sat_wr_val),
  .sat_flag    (sat_flag),
  .dest_we     (dest_we),
  .dest_idx    (dest_idx),
  .result      (result),
  .exec_fire   (exec_fire),
  .lane_clip   (lane_clip)
);

// File: tb/vsat_add_unit_test.sv
module vsat_add_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b;
  logic [4:0]   src_a_idx, src_b_idx, dest_idx;
  logic [127:0] result;
  logic         dest_we;
  logic         sat_wr_en, sat_wr_val, sat_flag;

  always #2ns clk = ~clk;   // 250 MHz

  vsat_add_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .result(result), .dest_we(dest_we), .dest_idx(dest_idx),
    .sat_wr_en(sat_wr_en), .sat_wr_val(sat_wr_val), .sat_flag(sat_flag)
  );

  typedef struct {
    logic [127:0] res;
    logic [4:0]   idx;
    logic         sat;
  } exp_t;

  exp_t         sbq[$];
  int           checks = 0;
  int           failures = 0;
  logic         model_sat = 1'b0;
  logic [31:0]  seed = 32'h1234_5678;
  int           cyc = 0;
  bit           done = 0;

  // Reference: widen to 64 bits, add, clamp.
  function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (s > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  function automatic bit ref_clipped(input logic [31:0] a, input logic [31:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic logic [31:0] mk(input int unsigned pri, input int unsigned vd,
                                     input int unsigned va, input int unsigned vb,
                                     input int unsigned xo);
    return {6'(pri), 5'(vd), 5'(va), 5'(vb), 11'(xo)};
  endfunction

  function automatic logic [31:0] lane_of(input logic [127:0] v, input int i);
    return v[127 - 32*i -: 32];
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: presents one cycle of stimulus and queues the expected write.
  task automatic issue(input bit v, input logic [31:0] ins,
                       input logic [127:0] a, input logic [127:0] b,
                       input bit we, input bit wv);
    exp_t e;
    bit   hit;
    bit   clipped;
    @(negedge clk);
    issue_valid = v; instr = ins; src_a = a; src_b = b;
    sat_wr_en = we; sat_wr_val = wv;
    hit = v && (ins[31:26] == 6'd4) && (ins[10:0] == 11'd896);
    clipped = 0;
    for (int i = 0; i < 4; i++) begin
      e.res[127 - 32*i -: 32] = ref_lane(lane_of(a, i), lane_of(b, i));
      clipped |= ref_clipped(lane_of(a, i), lane_of(b, i));
    end
    if (we) model_sat = wv;
    else if (hit && clipped) model_sat = 1'b1;
    e.idx = ins[25:21];
    e.sat = model_sat;
    @(posedge clk);
    if (hit) sbq.push_back(e);
    #1ns;
    issue_valid = 1'b0;
    sat_wr_en   = 1'b0;
  endtask

  // Monitor: compares every destination write against the queue head.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && dest_we === 1'b1) begin
      if (sbq.size() == 0) begin
        check(0, "R10", "unexpected dest_we", 128'd1, 128'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        for (int i = 0; i < 4; i++)
          check(lane_of(result, i) === lane_of(e.res, i), "R1", "lane sum",
                128'(lane_of(result, i)), 128'(lane_of(e.res, i)));
        check(dest_idx === e.idx, "R9", "dest_idx", 128'(dest_idx), 128'(e.idx));
        check(sat_flag === e.sat, "R6", "sat after execute", 128'(sat_flag), 128'(e.sat));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  localparam logic [31:0] MAXW = 32'h7FFF_FFFF;
  localparam logic [31:0] MINW = 32'h8000_0000;

  initial begin
    logic [127:0] prev;
    logic [31:0]  op;
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
    sat_wr_en = 1'b0; sat_wr_val = 1'b0;
    op = mk(4, 3, 1, 2, 896);

    repeat (3) @(negedge clk);
    check(result === '0, "R12", "reset result", result, '0);
    check(dest_we === 1'b0, "R12", "reset dest_we", 128'(dest_we), 0);
    check(sat_flag === 1'b0, "R12", "reset sat", 128'(sat_flag), 0);
    rst_n = 1'b1;

    // R1: mixed signs, plus a sum landing exactly on the positive limit (R3)
    issue(1, op, {32'd10, -32'sd20, 32'h4000_0000, -32'sd5},
                 {-32'sd3, 32'd7, 32'h3FFF_FFFF, -32'sd6}, 0, 0);
    @(negedge clk);
    check(result === {32'd7, -32'sd13, MAXW, -32'sd11}, "R1", "mixed sign", result,
          {32'd7, -32'sd13, MAXW, -32'sd11});
    check(sat_flag === 1'b0, "R3", "exact limit is not clipped", 128'(sat_flag), 0);

    // R2: lane order
    issue(1, op, {32'd1, 32'd2, 32'd3, 32'd4}, '0, 0, 0);
    @(negedge clk);
    check(result[127:96] === 32'd1, "R2", "lane0 at top", 128'(result[127:96]), 1);
    check(result[31:0] === 32'd4, "R2", "lane3 at bottom", 128'(result[31:0]), 4);

    // R3 / R5: max+1 beside a lane that wraps unsigned
    issue(1, op, {MAXW, 32'hFFFF_FFFF, 32'h64, MINW},
                 {32'd1, 32'd1, 32'd1, MAXW}, 0, 0);
    @(negedge clk);
    check(result[127:96] === MAXW, "R3", "max+1", 128'(result[127:96]), 128'(MAXW));
    check(result[95:0] === {32'd0, 32'h65, 32'hFFFF_FFFF}, "R5", "neighbours untouched",
          128'(result[95:0]), 128'({32'd0, 32'h65, 32'hFFFF_FFFF}));
    check(sat_flag === 1'b1, "R6", "clip sets sat", 128'(sat_flag), 1);

    // R7: sticky over non-saturating work and idle time
    issue(1, op, {32'd5, 32'd5, 32'd5, 32'd5}, {32'd1, 32'd1, 32'd1, 32'd1}, 0, 0);
    repeat (3) @(negedge clk);
    check(sat_flag === 1'b1, "R7", "sat stays set", 128'(sat_flag), 1);

    // R11: explicit clear
    issue(0, '0, '0, '0, 1, 0);
    @(negedge clk);
    check(sat_flag === 1'b0, "R11", "write clears", 128'(sat_flag), 0);

    // R4: negative clamp
    issue(1, op, {32'd0, 32'd0, MINW, MINW}, {32'd0, 32'd0, MINW, 32'hFFFF_FFFF}, 0, 0);
    @(negedge clk);
    check(result[63:0] === {MINW, MINW}, "R4", "min+(-1), min+min",
          128'(result[63:0]), 128'({MINW, MINW}));
    check(sat_flag === 1'b1, "R6", "negative clip sets sat", 128'(sat_flag), 1);

    // R11: clear in the same cycle as a saturating execute
    issue(1, op, {MAXW, 96'd0}, {MAXW, 96'd0}, 1, 0);
    @(negedge clk);
    check(sat_flag === 1'b0, "R11", "write beats set", 128'(sat_flag), 0);
    check(result[127:96] === MAXW, "R11", "result still written", 128'(result[127:96]),
          128'(MAXW));

    // R10: valid low with saturating operands
    prev = result;
    issue(0, op, {4{MAXW}}, {4{MAXW}}, 0, 0);
    @(negedge clk);
    check(dest_we === 1'b0, "R10", "no write when idle", 128'(dest_we), 0);
    check(result === prev, "R10", "result held", result, prev);
    check(sat_flag === 1'b0, "R10", "sat unchanged idle", 128'(sat_flag), 0);

    // R8: wrong extended code, then wrong primary code
    issue(1, mk(4, 3, 1, 2, 897), {4{MINW}}, {4{MINW}}, 0, 0);
    @(negedge clk);
    check(dest_we === 1'b0 && result === prev, "R8", "xo mismatch ignored", result, prev);
    check(sat_flag === 1'b0, "R8", "sat unchanged on xo mismatch", 128'(sat_flag), 0);
    issue(1, mk(5, 3, 1, 2, 896), {4{MAXW}}, {4{32'd1}}, 0, 0);
    @(negedge clk);
    check(dest_we === 1'b0 && result === prev, "R8", "primary mismatch ignored", result, prev);
    check(sat_flag === 1'b0, "R10", "sat unchanged on mismatch", 128'(sat_flag), 0);

    // R9: field extraction
    @(negedge clk);
    instr = mk(4, 17, 5, 30, 896);
    #1ns;
    check(src_a_idx === 5'd5, "R9", "src_a_idx", 128'(src_a_idx), 5);
    check(src_b_idx === 5'd30, "R9", "src_b_idx", 128'(src_b_idx), 30);
    issue(1, mk(4, 17, 5, 30, 896), {4{32'd2}}, {4{32'd3}}, 0, 0);
    @(negedge clk);
    check(dest_idx === 5'd17, "R9", "dest_idx", 128'(dest_idx), 17);

    // R11: explicit set
    issue(0, '0, '0, '0, 1, 1);
    @(negedge clk);
    check(sat_flag === 1'b1, "R11", "write sets", 128'(sat_flag), 1);

    // R1 / R6: random run, extremes one time in four; monitor scores it
    for (int n = 0; n < 80; n++) begin
      logic [127:0] a, b;
      for (int i = 0; i < 4; i++) begin
        seed = nxt(seed);
        a[127 - 32*i -: 32] = (seed[1:0] == 2'd0) ? (seed[2] ? MAXW : MINW) : seed;
        seed = nxt(seed);
        b[127 - 32*i -: 32] = (seed[1:0] == 2'd0) ? (seed[2] ? MAXW : MINW) : seed;
      end
      seed = nxt(seed);
      issue(1, mk(4, seed[8:4], seed[13:9], seed[18:14], 896), a, b,
            seed[23:20] == 4'd0, seed[24]);
    end

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R1", "all queued writes seen", 128'(sbq.size()), 0);
    check(sat_flag === model_sat, "R7", "final sat", 128'(sat_flag), 128'(model_sat));
    finish_run();
  end

endmodule